// File: doc/BRIEF.md
# Operand Address Generator with Bus-Cycle Penalties

This block forms the operand address for each instruction of an 8-bit processor with a 16-bit address space. A decoder hands it one request per instruction: an addressing mode, the access kind (read, write or read-modify-write), up to two operand bytes, both index registers, the program counter that follows the operand and, for branches, whether the branch was taken. The block returns the effective address, the number of bus cycles to add and, when the bus must do an extra read, the address of that read.

Direct modes finish one cycle after the request. The two indirect modes first fetch a two-byte pointer from page zero through a small read port. The memory behind that port answers in the same cycle. These modes finish three cycles after the request. For a read-modify-write request, the block then steps the bus through the read and write cycles of the access. The first of these cycles is the one in which `done` is high.

Top module: `ea_unit`

## Requirements
- R1: Modes 0 (page zero), 1 (page zero plus X) and 2 (page zero plus Y) give `ea` = {8'h00, (opnd_lo + index) mod 256} with `extra` = 0 and no dummy read, and `done` rises one cycle after the accepted `start`.
- R2: Mode 3 (absolute) gives `ea` = {opnd_hi, opnd_lo} with `extra` = 0, no dummy read and `done` one cycle after `start`.
- R3: For kind 0 (read) in modes 4 (absolute plus X) and 5 (absolute plus Y), `ea` = ({opnd_hi, opnd_lo} + index) mod 65536. When the high byte of `ea` differs from that of the base, `extra` = 1 and `dummy_rd` is high with `dummy_addr` equal to `ea` with bit 8 inverted. Otherwise `extra` = 0 and `dummy_rd` stays low.
- R4: For kind 1 (write) and kind 2 (read-modify-write) in modes 4, 5 and 7, `dummy_rd` is always high with `dummy_addr` = {base high byte, low byte of `ea`}, and `extra` = 0.
- R5: Mode 6 (X-indexed pointer) raises `zp_rd` in two consecutive cycles, at (opnd_lo + X) mod 256 and then at that address plus one mod 256. It gives `ea` = {second byte, first byte} with no dummy read, and `done` three cycles after `start`.
- R6: Mode 7 (pointer then plus Y) fetches the pointer bytes at opnd_lo and (opnd_lo + 1) mod 256 in consecutive cycles. It gives `ea` = (pointer + Y) mod 65536, applies R3 or R4 with the pointer as base, and raises `done` three cycles after `start`.
- R7: Mode 8 (relative branch) treats opnd_lo as a signed displacement. When `taken` is high, `ea` = (pc_next + displacement) mod 65536 and `extra` is 1, or 2 if `ea` lies on a different 256-byte page than pc_next. When `taken` is low, `ea` = pc_next and `extra` = 0. A branch never gives a dummy read or read-modify-write cycles.
- R8: Kind 2 in modes 3 to 7 drives `rmw_op` through 1 (read), 2 (write back the unchanged value) and 3 (write the new value) in three consecutive cycles, starting in the `done` cycle. After these, `rmw_op` returns to 0.
- R9: Kind 2 in modes 0 to 2 drives `rmw_op` through 1 and then 3 in consecutive cycles, starting in the `done` cycle, then 0.
- R10: A `start` while `busy` is high is ignored. The running request keeps its result and no additional `done` follows.
- R11: During and right after reset, `busy`, `done`, `zp_rd`, `dummy_rd` and `rmw_op` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when `busy` is low |
| mode | input | 4 | Addressing mode code 0..8 |
| kind | input | 2 | Access kind: 0 read, 1 write, 2 read-modify-write |
| taken | input | 1 | Branch outcome for mode 8 |
| opnd_lo | input | 8 | First operand byte or branch displacement |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc_next | input | 16 | Program counter after the operand bytes |
| zp_rd | output | 1 | Page-zero pointer read strobe |
| zp_addr | output | 8 | Page-zero pointer read address |
| zp_data | input | 8 | Page-zero read data, same cycle |
| busy | output | 1 | Request in progress; new `start` ignored |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| extra | output | 2 | Added bus cycles |
| dummy_rd | output | 1 | Extra read needed, valid with `done` |
| dummy_addr | output | 16 | Address of the extra read |
| rmw_op | output | 2 | Read-modify-write bus step: 0 none, 1 read, 2 write unchanged, 3 write new |

## Verification
The hardest case to reach is a pointer that wraps at the top of page zero and then carries into a new page when Y is added. The pointer bytes come from memory, not from the ports. The bench therefore computes the page-zero contents arithmetically from the address and sweeps every operand byte with several Y values, so that pointer offset 0xFF and all carry outcomes appear. A second request is also injected while the pointer fetch is running, to show that it is ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int AW = 16;
  parameter int DW = 8;
  parameter int MW = 4;

  typedef enum logic [MW-1:0] {
    M_ZP   = 4'd0,
    M_ZPX  = 4'd1,
    M_ZPY  = 4'd2,
    M_ABS  = 4'd3,
    M_ABSX = 4'd4,
    M_ABSY = 4'd5,
    M_INDX = 4'd6,
    M_INDY = 4'd7,
    M_REL  = 4'd8
  } amode_e;

  localparam logic [1:0] K_READ  = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] K_RMW   = 2'd2;

  typedef struct packed {
    logic [AW-1:0] ea;
    logic [1:0]    extra;
    logic          dmy_vld;
    logic [AW-1:0] dmy;
  } ea_res_t;

  // 8-bit add that stays inside page zero
  function automatic logic [DW-1:0] zp_wrap(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic on_new_page(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:DW] != b[AW-1:DW];
  endfunction

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] pc, input logic [DW-1:0] disp);
    return pc + {{(AW-DW){disp[DW-1]}}, disp};
  endfunction

  function automatic logic is_zp_form(input amode_e m);
    return (m == M_ZP) || (m == M_ZPX) || (m == M_ZPY);
  endfunction

  function automatic logic is_indirect(input amode_e m);
    return (m == M_INDX) || (m == M_INDY);
  endfunction

  function automatic logic [DW-1:0] pick_index(input amode_e m, input logic [DW-1:0] x,
                                               input logic [DW-1:0] y);
    case (m)
      M_ZPX, M_ABSX:         return x;
      M_ZPY, M_ABSY, M_INDY: return y;
      default:               return '0;
    endcase
  endfunction
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  amode_e        mode,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic [AW-1:0] pc,
  input  logic          taken,
  output ea_res_t       res,
  output logic          page_cross
);
  localparam logic [AW-1:0] PAGE_FLIP = {{(AW-DW-1){1'b0}}, 1'b1, {DW{1'b0}}};

  logic [AW-1:0] sum;
  logic [AW-1:0] tgt;
  logic          rd;

  always_comb begin
    sum        = base + {{(AW-DW){1'b0}}, idx};
    tgt        = rel_target(pc, base[DW-1:0]);
    rd         = (kind == K_READ);
    page_cross = 1'b0;
    res        = '0;
    case (mode)
      M_ABS, M_INDX: res.ea = base;
      M_ABSX, M_ABSY, M_INDY: begin
        res.ea = sum;
        if (rd) begin
          page_cross  = on_new_page(sum, base);
          res.extra   = {1'b0, page_cross};
          res.dmy_vld = page_cross;
          res.dmy     = sum ^ PAGE_FLIP;
        end else begin
          res.dmy_vld = 1'b1;
          res.dmy     = {base[AW-1:DW], sum[DW-1:0]};
        end
      end
      M_REL: begin
        if (taken) begin
          page_cross = on_new_page(tgt, pc);
          res.ea     = tgt;
          res.extra  = page_cross ? 2'd2 : 2'd1;
        end else begin
          res.ea = pc;
        end
      end
      default: res.ea = {{(AW-DW){1'b0}}, zp_wrap(base[DW-1:0], idx)};
    endcase
  end
endmodule

// File: rtl/ea_rmw_seq.sv
module ea_rmw_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       zp_form,
  output logic [1:0] rmw_op,
  output logic       active
);
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WO   = 2'd2,
    PH_WN   = 2'd3
  } ph_e;

  ph_e  ph_q;
  logic zp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      zp_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (launch) begin
          ph_q <= PH_RD;
          zp_q <= zp_form;
        end
        PH_RD:   ph_q <= zp_q ? PH_WN : PH_WO;
        PH_WO:   ph_q <= PH_WN;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign rmw_op = ph_q;
  assign active = (ph_q != PH_IDLE);

  // R8: the unchanged write-back is always followed by the modified write
  a_r8_back_then_new: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_op == 2'd2 |=> rmw_op == 2'd3);
  // R9: page-zero form goes straight from read to modified write
  a_r9_zp_skips_back: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_op == 2'd1) && zp_q |=> rmw_op == 2'd3);
  // R8: every sequence opens with the read step
  a_r8_opens_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_op == 2'd0) && launch |=> rmw_op == 2'd1);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic [1:0]    kind,
  input  logic          taken,
  input  logic [DW-1:0] opnd_lo,
  input  logic [DW-1:0] opnd_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [AW-1:0] pc_next,
  output logic          zp_rd,
  output logic [DW-1:0] zp_addr,
  input  logic [DW-1:0] zp_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [1:0]    extra,
  output logic          dummy_rd,
  output logic [AW-1:0] dummy_addr,
  output logic [1:0]    rmw_op
);
  typedef enum logic [1:0] {S_IDLE, S_PTR_LO, S_PTR_HI} fst_e;

  fst_e          st_q;
  amode_e        mode_in, mode_q, calc_mode, res_mode_q;
  logic [1:0]    kind_q, calc_kind, res_kind_q;
  logic [DW-1:0] ptr_q, lo_q, idx_q, calc_idx;
  logic [AW-1:0] calc_base, calc_pc;
  logic          calc_taken;
  ea_res_t       calc_res, res_q;
  logic          page_cross;
  logic          accept, finish, launch, rmw_active, done_q;

  assign mode_in = amode_e'(mode);
  assign accept  = start && !busy;
  assign finish  = (accept && !is_indirect(mode_in)) || (st_q == S_PTR_HI);
  assign launch  = finish && (calc_kind == K_RMW) && (calc_mode != M_REL);

  // operands come from the ports, or from the pointer fetch in its last cycle
  always_comb begin
    if (st_q == S_PTR_HI) begin
      calc_mode  = mode_q;
      calc_kind  = kind_q;
      calc_base  = {zp_data, lo_q};
      calc_idx   = idx_q;
      calc_pc    = '0;
      calc_taken = 1'b0;
    end else begin
      calc_mode  = mode_in;
      calc_kind  = kind;
      calc_base  = {opnd_hi, opnd_lo};
      calc_idx   = pick_index(mode_in, idx_x, idx_y);
      calc_pc    = pc_next;
      calc_taken = taken;
    end
  end

  ea_calc u_calc (
    .mode       (calc_mode),
    .kind       (calc_kind),
    .base       (calc_base),
    .idx        (calc_idx),
    .pc         (calc_pc),
    .taken      (calc_taken),
    .res        (calc_res),
    .page_cross (page_cross)
  );

  ea_rmw_seq u_rmw (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .zp_form (is_zp_form(calc_mode)),
    .rmw_op  (rmw_op),
    .active  (rmw_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      ptr_q      <= '0;
      lo_q       <= '0;
      idx_q      <= '0;
      mode_q     <= M_ZP;
      kind_q     <= '0;
      done_q     <= 1'b0;
      res_q      <= '0;
      res_mode_q <= M_ZP;
      res_kind_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) begin
        res_q      <= calc_res;
        res_mode_q <= calc_mode;
        res_kind_q <= calc_kind;
      end
      case (st_q)
        S_IDLE: if (accept && is_indirect(mode_in)) begin
          st_q   <= S_PTR_LO;
          ptr_q  <= zp_wrap(opnd_lo, (mode_in == M_INDX) ? idx_x : '0);
          idx_q  <= pick_index(mode_in, idx_x, idx_y);
          mode_q <= mode_in;
          kind_q <= kind;
        end
        S_PTR_LO: begin
          lo_q <= zp_data;
          st_q <= S_PTR_HI;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign zp_rd      = (st_q != S_IDLE);
  assign zp_addr    = (st_q == S_PTR_HI) ? zp_wrap(ptr_q, DW'(1)) : ptr_q;
  assign busy       = (st_q != S_IDLE) || rmw_active;
  assign done       = done_q;
  assign ea         = res_q.ea;
  assign extra      = res_q.extra;
  assign dummy_rd   = done_q && res_q.dmy_vld;
  assign dummy_addr = res_q.dmy;

  // R3: a read result carries a dummy read exactly when one cycle is added
  a_r3_read_dummy_tracks_extra: assert property (@(posedge clk) disable iff (!rst_n)
    done && (res_kind_q == K_READ) && (res_mode_q != M_REL) |-> dummy_rd == (extra == 2'd1));
  // R4: writes and read-modify-writes never pay a page-cross cycle
  a_r4_write_no_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    done && (res_kind_q != K_READ) && (res_mode_q != M_REL) |-> extra == 2'd0);
  // R5: the two pointer reads are at consecutive page-zero addresses
  a_r5_ptr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    zp_rd && $past(zp_rd) |-> zp_addr == zp_wrap($past(zp_addr), DW'(1)));
  // R7: only a branch can add two cycles
  a_r7_two_only_branch: assert property (@(posedge clk) disable iff (!rst_n)
    done && (extra == 2'd2) |-> res_mode_q == M_REL);
  // R10: a pointer fetch runs to its second byte whatever start does
  a_r10_fetch_progress: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_PTR_LO |=> st_q == S_PTR_HI);
endmodule

// File: tb/test_ea_unit.sv
module test_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  kind = '0;
  logic        taken = 1'b0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc_next = '0;
  logic        zp_rd, busy, done, dummy_rd;
  logic [7:0]  zp_addr, zp_data;
  logic [15:0] ea, dummy_addr;
  logic [1:0]  extra, rmw_op;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  int  ivals[4] = '{0, 1, 128, 255};

  always #2 clk = ~clk;

  function automatic int zp_fn(int a);
    return (a * 29 + 83) % 256;
  endfunction

  always_comb zp_data = 8'(zp_fn(int'(zp_addr)));

  ea_unit i_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .kind(kind), .taken(taken),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y), .pc_next(pc_next),
    .zp_rd(zp_rd), .zp_addr(zp_addr), .zp_data(zp_data), .busy(busy), .done(done),
    .ea(ea), .extra(extra), .dummy_rd(dummy_rd), .dummy_addr(dummy_addr), .rmw_op(rmw_op)
  );

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input int m, input int k, input int lo, input int hi, input int x,
                        input int y, input int pc, input int tk, input string rq);
    int base, ix, sum, e_ea, e_ex, e_dv, e_da, e_lat, p, d, t, lat, zn, sn, e_sn;
    int za[2];
    int seq[4];
    int e_seq[4];
    bit indexed;
    string srq;
    e_ex = 0; e_dv = 0; e_da = 0; e_lat = 1; indexed = 0; base = 0; ix = 0; p = 0; e_ea = 0;
    case (m)
      0: e_ea = lo;
      1: e_ea = (lo + x) % 256;
      2: e_ea = (lo + y) % 256;
      3: e_ea = hi * 256 + lo;
      4: begin base = hi * 256 + lo; ix = x; indexed = 1; end
      5: begin base = hi * 256 + lo; ix = y; indexed = 1; end
      6: begin p = (lo + x) % 256; e_ea = zp_fn((p + 1) % 256) * 256 + zp_fn(p); e_lat = 3; end
      7: begin p = lo; base = zp_fn((p + 1) % 256) * 256 + zp_fn(p); ix = y; indexed = 1; e_lat = 3; end
      default: begin
        d = (lo >= 128) ? lo - 256 : lo;
        t = (pc + d + 65536) % 65536;
        if (tk != 0) begin e_ea = t; e_ex = ((t / 256) != (pc / 256)) ? 2 : 1; end
        else e_ea = pc;
      end
    endcase
    if (indexed) begin
      sum = (base + ix) % 65536;
      e_ea = sum;
      if (k == 0) begin
        if ((sum / 256) != (base / 256)) begin
          e_ex = 1; e_dv = 1; e_da = ((sum / 256) ^ 1) * 256 + sum % 256;
        end
      end else begin
        e_dv = 1; e_da = (base / 256) * 256 + sum % 256;
      end
    end
    e_sn = 0;
    if (k == 2 && m != 8) begin
      e_seq[0] = 1;
      if (m <= 2) begin e_seq[1] = 3; e_sn = 2; end
      else begin e_seq[1] = 2; e_seq[2] = 3; e_sn = 3; end
    end

    @(negedge clk);
    start = 1'b1; mode = 4'(m); kind = 2'(k); opnd_lo = 8'(lo); opnd_hi = 8'(hi);
    idx_x = 8'(x); idx_y = 8'(y); pc_next = 16'(pc); taken = tk[0];
    @(negedge clk);
    start = 1'b0;
    lat = 1; zn = 0;
    while (!done && lat < 8) begin
      if (zp_rd && zn < 2) begin za[zn] = int'(zp_addr); zn++; end
      @(negedge clk);
      lat++;
    end
    check(lat == e_lat, rq, "latency", lat, e_lat);
    check(int'(ea) == e_ea, rq, "ea", int'(ea), e_ea);
    check(int'(extra) == e_ex, rq, "extra", int'(extra), e_ex);
    check(int'(dummy_rd) == e_dv, rq, "dummy_rd", int'(dummy_rd), e_dv);
    if (e_dv != 0) check(int'(dummy_addr) == e_da, rq, "dummy_addr", int'(dummy_addr), e_da);
    if (m == 6 || m == 7) begin
      check(zn == 2, rq, "pointer read count", zn, 2);
      if (zn == 2) begin
        check(za[0] == p, rq, "pointer low addr", za[0], p);
        check(za[1] == (p + 1) % 256, rq, "pointer high addr", za[1], (p + 1) % 256);
      end
    end
    sn = 0;
    for (int i = 0; i < 6; i++) begin
      if (rmw_op != 2'd0 && sn < 4) begin seq[sn] = int'(rmw_op); sn++; end
      if (!busy) break;
      @(negedge clk);
    end
    srq = (k == 2 && m != 8) ? ((m <= 2) ? "R9" : "R8") : rq;
    check(sn == e_sn, srq, "rmw step count", sn, e_sn);
    if (sn == e_sn)
      for (int i = 0; i < e_sn; i++) check(seq[i] == e_seq[i], srq, "rmw step", seq[i], e_seq[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: quiet outputs in and right after reset
    check(busy == 1'b0 && done == 1'b0 && zp_rd == 1'b0, "R11", "strobes in reset",
          int'({busy, done, zp_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'({busy, done, zp_rd, dummy_rd}) == 0, "R11", "strobes after reset",
          int'({busy, done, zp_rd, dummy_rd}), 0);
    check(rmw_op == 2'd0, "R11", "rmw_op after reset", int'(rmw_op), 0);

    // R1: page-zero modes, every operand byte
    for (int m = 0; m < 3; m++)
      for (int lo = 0; lo < 256; lo++) run_op(m, 0, lo, 8'hA5, 8'hF3, 8'h0D, 0, 0, "R1");
    // R2: absolute
    for (int lo = 0; lo < 256; lo += 15) run_op(3, 0, lo, 255 - lo, 8'h44, 8'h55, 0, 0, "R2");
    // R3: indexed reads, with and without page cross and top-of-memory wrap
    for (int m = 4; m < 6; m++)
      for (int h = 0; h < 2; h++)
        for (int v = 0; v < 4; v++)
          for (int lo = 0; lo < 256; lo++)
            run_op(m, 0, lo, (h == 0) ? 8'h12 : 8'hFF, ivals[v], ivals[v], 0, 0, "R3");
    // R4: writes and read-modify-writes in indexed modes (R6 for mode 7)
    for (int m = 4; m < 8; m++)
      for (int k = 1; k < 3; k++)
        for (int v = 0; v < 4; v++)
          for (int lo = 0; lo < 256; lo += 5)
            if (m != 6) run_op(m, k, lo, 8'hFF - lo, ivals[v], ivals[v], 0, 0, (m == 7) ? "R6" : "R4");
    // R5: X-indexed pointer, including the page-zero wrap at 0xFF
    for (int lo = 0; lo < 256; lo++) run_op(6, 0, lo, 0, 8'h35, 8'h00, 0, 0, "R5");
    run_op(6, 2, 8'hCA, 0, 8'h35, 0, 0, 0, "R5");
    // R6: pointer then Y, read form
    for (int v = 0; v < 4; v++)
      for (int lo = 0; lo < 256; lo++) run_op(7, 0, lo, 0, 8'h00, ivals[v] ^ 8'h10, 0, 0, "R6");
    // R7: branches, both outcomes, near page edges; kind 2 must not start rmw steps
    for (int pi = 0; pi < 4; pi++)
      for (int tk = 0; tk < 2; tk++)
        for (int d = 0; d < 256; d++)
          run_op(8, (d % 3 == 0) ? 2 : 0, d, 0, 0, 0,
                 (pi == 0) ? 16'h10FE : (pi == 1) ? 16'h8000 : (pi == 2) ? 16'hFFF0 : 16'h0005, tk, "R7");
    // R8, R9: read-modify-write on absolute and page-zero forms
    run_op(3, 2, 8'h34, 8'h12, 0, 0, 0, 0, "R8");
    run_op(0, 2, 8'h34, 8'h00, 0, 0, 0, 0, "R9");
    run_op(1, 2, 8'hF0, 8'h00, 8'h20, 0, 0, 0, "R9");

    // R10: a second start during the pointer fetch has no effect
    @(negedge clk);
    start = 1'b1; mode = 4'd6; kind = 2'd0; opnd_lo = 8'h10; idx_x = 8'h01; idx_y = 8'h00;
    @(negedge clk);
    mode = 4'd0; opnd_lo = 8'h77;
    check(busy == 1'b1, "R10", "busy during fetch", int'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R10", "done of first request", int'(done), 1);
    check(int'(ea) == zp_fn(8'h12) * 256 + zp_fn(8'h11), "R10", "ea unaffected",
          int'(ea), zp_fn(8'h12) * 256 + zp_fn(8'h11));
    @(negedge clk);
    check(done == 1'b0, "R10", "no second done", int'(done), 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", "stays idle", int'({done, busy}), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule